// File: doc/BRIEF.md
# Kd-Tree Ray Traversal Engine

This block walks a binary space-partitioning tree for a single ray and reports, nearest first, every leaf cell the ray passes through together with the parametric distance interval the ray spends inside that cell. Each interior node cuts space with one axis-aligned plane. The engine computes the ray's distance to that plane and then takes one of three routes: the near child only, the far child only, or the near child with the lower part of the interval followed later by the far child with the upper part. Far children that are deferred wait on an internal last-in-first-out stack.

A caller loads the ray origin, the per-axis inverse direction and the starting interval with a one-cycle start pulse. The engine fetches nodes through a combinational read port into a node store outside the block. Each leaf is announced by a one-cycle pulse carrying the leaf's primitive-list pointer and its interval. A separate distance input reports the closest hit found so far, so the walk can stop as soon as every remaining deferred cell begins beyond that hit. All distances, coordinates and plane positions are signed 16.16 fixed point.

Top module: `kdt_trav_top`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `leaf_valid` are low until a start pulse is accepted.
- R2: A node word is 43 bits: bit 42 is the leaf flag, bits 41:40 the split axis (0 = x, 1 = y, 2 and 3 = z), bits 39:8 the signed plane position and bits 7:0 the child index. An interior node's children sit at `child` and `child+1`, and a leaf's child field is its primitive-list pointer. The walk begins at node 0.
- R3: The plane distance is t* = ((split - origin[axis]) * invdir[axis]) shifted right arithmetically by 16, saturated to the signed 32-bit range.
- R4: The near child is node `child` when origin[axis] is below the split value (signed) and node `child+1` otherwise. The other child is the far one.
- R5: When t* is greater than the current tmax, or t* is negative, only the near child is visited, with the interval unchanged.
- R6: When t* is not negative, not above tmax and below tmin, only the far child is visited, with the interval unchanged.
- R7: In every other case the near child is visited at once with [tmin, t*] and the far child is deferred with [t*, tmax]. The stack holds 16 deferred entries, and a deferral made while it is full is discarded.
- R8: An inverse direction component of zero on the split axis marks a ray parallel to the plane, and only the near child is visited.
- R9: The first node is fetched in the cycle after start is accepted, and each interior node takes three cycles. A leaf fetched in cycle k gives a `leaf_valid` pulse in cycle k+1 with its pointer, tmin and tmax. Leaves appear in near-to-far order.
- R10: After each leaf the most recent deferred entry is popped and walked from the next cycle. If `hit_t` is strictly less than that entry's tmin, the walk ends instead and the remaining entries are dropped.
- R11: When the walk ends (stack empty after a leaf, or R10), `busy` falls and `done` rises two cycles after the last leaf fetch. `done` stays high until the next start, and a start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk with the ray inputs below |
| org_x | input | 32 | Ray origin x, signed 16.16 |
| org_y | input | 32 | Ray origin y, signed 16.16 |
| org_z | input | 32 | Ray origin z, signed 16.16 |
| inv_x | input | 32 | Inverse direction x, 0 means parallel |
| inv_y | input | 32 | Inverse direction y, 0 means parallel |
| inv_z | input | 32 | Inverse direction z, 0 means parallel |
| t_enter | input | 32 | Starting tmin |
| t_exit | input | 32 | Starting tmax |
| hit_t | input | 32 | Closest hit distance known so far |
| node_addr | output | 8 | Node store read index |
| node_data | input | 43 | Node word at node_addr, same cycle |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, held until next start |
| leaf_valid | output | 1 | One-cycle leaf report |
| leaf_ref | output | 8 | Primitive-list pointer of the reported leaf |
| leaf_t0 | output | 32 | Entry distance of the reported leaf |
| leaf_t1 | output | 32 | Exit distance of the reported leaf |

## Verification
On every cycle the assertions check the invariants of the stack and the route logic: the fill level stays within its depth, each pop lowers it by exactly one, a deferred entry's split distance lies inside the interval being divided, a leaf report lasts one cycle, and a pop that meets an earlier hit ends the walk in the next cycle. The order and intervals of the reported leaves, the choice among the three routes, the fixed-point plane distance, the way a tree deeper than the stack loses its deepest far children, and early stopping all depend on the tree and ray contents. Only the bench scenarios show these, by comparing the outputs cycle by cycle with a behavioural model of the walk.

// File: rtl/kdt_pkg.sv
package kdt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_CALC   = 3'd2,
    ST_DECIDE = 3'd3,
    ST_POP    = 3'd4
  } walk_state_e;

  typedef enum logic [1:0] {
    RT_NEAR = 2'd0,
    RT_FAR  = 2'd1,
    RT_BOTH = 2'd2
  } route_e;

endpackage

// File: rtl/kdt_plane_dist.sv
module kdt_plane_dist #(
  parameter int W    = 32,
  parameter int FRAC = 16
) (
  input  logic signed [W-1:0] split_pos,
  input  logic signed [W-1:0] origin,
  input  logic signed [W-1:0] inv_dir,
  output logic signed [W-1:0] t_plane
);
  localparam int PW = 2*W + 1;

  logic signed [W:0]    diff;
  logic signed [PW-1:0] a_ext, b_ext, prod, prod_sh;
  logic                 ovf;

  always_comb begin
    diff    = {split_pos[W-1], split_pos} - {origin[W-1], origin};
    a_ext   = {{W{diff[W]}}, diff};
    b_ext   = {{(W+1){inv_dir[W-1]}}, inv_dir};
    prod    = a_ext * b_ext;
    prod_sh = prod >>> FRAC;
    // upper bits must all equal the result's sign bit
    ovf     = !((&prod_sh[PW-1:W-1]) || !(|prod_sh[PW-1:W-1]));
    if (ovf) begin
      t_plane = prod_sh[PW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      t_plane = prod_sh[W-1:0];
    end
  end

endmodule

// File: rtl/kdt_route.sv
module kdt_route
  import kdt_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = 8
) (
  input  logic signed [W-1:0] t_plane,
  input  logic signed [W-1:0] t_lo,
  input  logic signed [W-1:0] t_hi,
  input  logic                parallel,
  input  logic                below,
  input  logic [IDX_W-1:0]    child,
  output route_e              route,
  output logic [IDX_W-1:0]    near_idx,
  output logic [IDX_W-1:0]    far_idx
);
  logic [IDX_W-1:0] sibling;

  always_comb begin
    sibling  = child + IDX_W'(1);
    near_idx = below ? child : sibling;
    far_idx  = below ? sibling : child;
    if (parallel || t_plane[W-1] || (t_plane > t_hi)) begin
      route = RT_NEAR;
    end else if (t_plane < t_lo) begin
      route = RT_FAR;
    end else begin
      route = RT_BOTH;
    end
  end

endmodule

// File: rtl/kdt_lifo.sv
module kdt_lifo #(
  parameter int DEPTH = 16,
  parameter int EW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] din,
  output logic [EW-1:0] dout,
  output logic          empty,
  output logic          full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [EW-1:0] slot_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = slot_q[cnt_q[PW-1:0] - PW'(1)];

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (do_push && !do_pop) begin
      cnt_d = cnt_q + CW'(1);
    end else if (do_pop && !do_push) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (cnt_q[PW-1:0] == PW'(g))) begin
        slot_q[g] <= din;
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/kdt_trav_top.sv
module kdt_trav_top
  import kdt_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int W     = 32,
  parameter int FRAC  = 16,
  parameter int DEPTH = 16,
  parameter int ROOT  = 0,
  localparam int NODE_W = 3 + W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] org_x,
  input  logic signed [W-1:0] org_y,
  input  logic signed [W-1:0] org_z,
  input  logic signed [W-1:0] inv_x,
  input  logic signed [W-1:0] inv_y,
  input  logic signed [W-1:0] inv_z,
  input  logic signed [W-1:0] t_enter,
  input  logic signed [W-1:0] t_exit,
  input  logic signed [W-1:0] hit_t,
  output logic [IDX_W-1:0]    node_addr,
  input  logic [NODE_W-1:0]   node_data,
  output logic                busy,
  output logic                done,
  output logic                leaf_valid,
  output logic [IDX_W-1:0]    leaf_ref,
  output logic signed [W-1:0] leaf_t0,
  output logic signed [W-1:0] leaf_t1
);
  localparam int EW = IDX_W + 2*W;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  walk_state_e         state_q, state_d;
  logic [IDX_W-1:0]    node_q, node_d;
  logic signed [W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic                done_q, done_d, lv_q, lv_d;
  logic signed [W-1:0] org_q [3];
  logic signed [W-1:0] inv_q [3];
  logic [1:0]          ax_q;
  logic signed [W-1:0] split_q;
  logic [IDX_W-1:0]    child_q;
  logic signed [W-1:0] ts_q, ts_c;
  logic [IDX_W-1:0]    lref_q;
  logic signed [W-1:0] lt0_q, lt1_q;
  logic                ray_ld, nd_ld, ts_ld, push, pop;
  logic                is_leaf;
  logic [1:0]          ax_sel;
  logic signed [W-1:0] org_sel, inv_sel;
  route_e              route;
  logic [IDX_W-1:0]    near_idx, far_idx;
  logic [EW-1:0]       top_ent;
  logic                stk_empty, stk_full;
  logic [IDX_W-1:0]    top_idx;
  logic signed [W-1:0] top_lo, top_hi;
  logic                stop_now;

  assign is_leaf = node_data[NODE_W-1];
  assign ax_sel  = (ax_q == 2'd3) ? 2'd2 : ax_q;
  assign org_sel = org_q[ax_sel];
  assign inv_sel = inv_q[ax_sel];
  assign top_idx = top_ent[EW-1 -: IDX_W];
  assign top_lo  = $signed(top_ent[2*W-1:W]);
  assign top_hi  = $signed(top_ent[W-1:0]);
  assign stop_now = stk_empty || (hit_t < top_lo);

  kdt_plane_dist #(.W(W), .FRAC(FRAC)) u_dist (
    .split_pos (split_q),
    .origin    (org_sel),
    .inv_dir   (inv_sel),
    .t_plane   (ts_c)
  );

  kdt_route #(.W(W), .IDX_W(IDX_W)) u_route (
    .t_plane  (ts_q),
    .t_lo     (lo_q),
    .t_hi     (hi_q),
    .parallel (inv_sel == '0),
    .below    (org_sel < split_q),
    .child    (child_q),
    .route    (route),
    .near_idx (near_idx),
    .far_idx  (far_idx)
  );

  kdt_lifo #(.DEPTH(DEPTH), .EW(EW)) u_stack (
    .clk   (clk),
    .rst_n (rst_i),
    .clr   (ray_ld),
    .push  (push),
    .pop   (pop),
    .din   ({far_idx, ts_q, hi_q}),
    .dout  (top_ent),
    .empty (stk_empty),
    .full  (stk_full)
  );

  // next state
  always_comb begin
    state_d = state_q;
    node_d  = node_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    done_d  = done_q;
    lv_d    = 1'b0;
    ray_ld  = 1'b0;
    nd_ld   = 1'b0;
    ts_ld   = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ray_ld  = 1'b1;
          node_d  = IDX_W'(ROOT);
          lo_d    = t_enter;
          hi_d    = t_exit;
          done_d  = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        nd_ld = 1'b1;
        if (is_leaf) begin
          lv_d    = 1'b1;
          state_d = ST_POP;
        end else begin
          state_d = ST_CALC;
        end
      end
      ST_CALC: begin
        ts_ld   = 1'b1;
        state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        unique case (route)
          RT_FAR:  node_d = far_idx;
          RT_BOTH: begin
            node_d = near_idx;
            hi_d   = ts_q;
            push   = 1'b1;
          end
          default: node_d = near_idx;
        endcase
        state_d = ST_FETCH;
      end
      ST_POP: begin
        if (stop_now) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          pop     = 1'b1;
          node_d  = top_idx;
          lo_d    = top_lo;
          hi_d    = top_hi;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      lv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      lv_q    <= lv_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    node_q <= node_d;
    lo_q   <= lo_d;
    hi_q   <= hi_d;
    if (ray_ld) begin
      org_q[0] <= org_x;  org_q[1] <= org_y;  org_q[2] <= org_z;
      inv_q[0] <= inv_x;  inv_q[1] <= inv_y;  inv_q[2] <= inv_z;
    end
    if (nd_ld) begin
      ax_q    <= node_data[NODE_W-2 -: 2];
      split_q <= $signed(node_data[IDX_W+W-1:IDX_W]);
      child_q <= node_data[IDX_W-1:0];
    end
    if (ts_ld) begin
      ts_q <= ts_c;
    end
    if (lv_d) begin
      lref_q <= node_data[IDX_W-1:0];
      lt0_q  <= lo_q;
      lt1_q  <= hi_q;
    end
  end

  assign node_addr  = node_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign leaf_valid = lv_q;
  assign leaf_ref   = lref_q;
  assign leaf_t0    = lt0_q;
  assign leaf_t1    = lt1_q;

  // R9
  leaf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    lv_q |=> !lv_q);

  // R7
  split_bounds_chk: assert property (@(posedge clk) disable iff (!rst_i)
    push |-> ((ts_q >= lo_q) && (ts_q <= hi_q)));

  // R10
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_POP && !stk_empty && (hit_t < top_lo)) |=> (done_q && !busy));

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_i)
    done_q |-> !busy);

endmodule

// File: tb/sim_kdt_trav_top.sv
`timescale 1ns/1ps
module sim_kdt_trav_top;
  localparam int IW = 8;
  localparam int NW = 3 + 32 + IW;
  localparam int ONE = 65536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [31:0] org_x = '0, org_y = '0, org_z = '0;
  logic signed [31:0] inv_x = '0, inv_y = '0, inv_z = '0;
  logic signed [31:0] t_enter = '0, t_exit = '0, hit_t = '0;
  logic [IW-1:0] node_addr;
  logic [NW-1:0] node_data;
  logic busy, done, leaf_valid;
  logic [IW-1:0] leaf_ref;
  logic signed [31:0] leaf_t0, leaf_t1;

  logic [NW-1:0] mem [256];
  assign node_data = mem[node_addr];

  always #2.5 clk = ~clk;

  kdt_trav_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .org_x(org_x), .org_y(org_y), .org_z(org_z),
    .inv_x(inv_x), .inv_y(inv_y), .inv_z(inv_z),
    .t_enter(t_enter), .t_exit(t_exit), .hit_t(hit_t),
    .node_addr(node_addr), .node_data(node_data),
    .busy(busy), .done(done), .leaf_valid(leaf_valid),
    .leaf_ref(leaf_ref), .leaf_t0(leaf_t0), .leaf_t1(leaf_t1)
  );

  int total = 0;
  int bad = 0;
  int exp_lv [1024];
  int exp_ref [1024];
  int exp_lo [1024];
  int exp_hi [1024];
  int exp_end;
  int obs_ref [$];
  int obs_hi [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [NW-1:0] mk(input bit leaf, input int ax,
                                       input int spl, input int c);
    return {leaf, 2'(ax), 32'(spl), 8'(c)};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  // behavioural walk: recursion flattened onto queues, cycle costs per R9
  task automatic build_exp(input int ox, oy, oz, ix, iy, iz, lo0, hi0, hit);
    int k, node, lo, hi, o, iv, spl, ts, c, nr, fr;
    longint p;
    logic [NW-1:0] w;
    int qn [$];
    int ql [$];
    int qh [$];
    for (int i = 0; i < 1024; i++) exp_lv[i] = 0;
    k = 1; node = 0; lo = lo0; hi = hi0;
    forever begin
      w = mem[node];
      if (w[NW-1]) begin
        exp_lv[k+1] = 1;
        exp_ref[k+1] = int'(w[IW-1:0]);
        exp_lo[k+1] = lo;
        exp_hi[k+1] = hi;
        if (qn.size() == 0 || hit < ql[$]) begin
          exp_end = k + 2;
          break;
        end
        node = qn.pop_back(); lo = ql.pop_back(); hi = qh.pop_back();
        k += 2;
      end else begin
        case (int'(w[NW-2:NW-3]))
          0: begin o = ox; iv = ix; end
          1: begin o = oy; iv = iy; end
          default: begin o = oz; iv = iz; end
        endcase
        spl = int'($signed(w[IW+31:IW]));
        p = (longint'(spl) - longint'(o)) * longint'(iv);
        p = p >>> 16;
        if (p > 64'sd2147483647) p = 64'sd2147483647;
        if (p < -64'sd2147483648) p = -64'sd2147483648;
        ts = int'(p);
        c = int'(w[IW-1:0]);
        if (o < spl) begin nr = c; fr = (c + 1) & 255; end
        else begin nr = (c + 1) & 255; fr = c; end
        if (iv == 0 || ts < 0 || ts > hi) node = nr;
        else if (ts < lo) node = fr;
        else begin
          if (qn.size() < 16) begin
            qn.push_back(fr); ql.push_back(ts); qh.push_back(hi);
          end
          node = nr;
          hi = ts;
        end
        k += 3;
      end
    end
  endtask

  task automatic run_case(input string tag, input int ox, oy, oz, ix, iy, iz,
                          input int lo0, hi0, hit, input bit restart);
    build_exp(ox, oy, oz, ix, iy, iz, lo0, hi0, hit);
    obs_ref.delete();
    obs_hi.delete();
    @(negedge clk);
    org_x = ox; org_y = oy; org_z = oz;
    inv_x = ix; inv_y = iy; inv_z = iz;
    t_enter = lo0; t_exit = hi0; hit_t = hit;
    start = 1'b1;
    for (int c = 1; c <= exp_end; c++) begin
      @(negedge clk);
      if (c == 1) start = 1'b0;
      if (restart && c == 3) start = 1'b1;
      if (restart && c == 4) start = 1'b0;
      chk(busy == (c < exp_end), tag, "busy", busy, c < exp_end);
      chk(done == (c == exp_end), tag, "done", done, c == exp_end);
      chk(leaf_valid == exp_lv[c][0], tag, "leaf_valid", leaf_valid, exp_lv[c]);
      if (leaf_valid) begin
        obs_ref.push_back(int'(leaf_ref));
        obs_hi.push_back(int'(leaf_t1));
      end
      if (exp_lv[c] != 0 && leaf_valid) begin
        chk(int'(leaf_ref) == exp_ref[c], tag, "leaf_ref", leaf_ref, exp_ref[c]);
        chk(leaf_t0 == exp_lo[c], tag, "leaf_t0", leaf_t0, exp_lo[c]);
        chk(leaf_t1 == exp_hi[c], tag, "leaf_t1", leaf_t1, exp_hi[c]);
      end
    end
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      chk(done && !busy, "R11", "done held", done, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !leaf_valid, "R1", "in reset", {busy, done, leaf_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !leaf_valid, "R1", "after reset", {busy, done, leaf_valid}, 0);

    // single leaf at the root
    mem[0] = mk(1, 0, 0, 9);
    run_case("R9", -5*ONE, 0, 0, ONE, ONE, ONE, 0, 10*ONE, 32'sh7fffffff, 0);
    chk(obs_ref.size() == 1, "R9", "leaf count", obs_ref.size(), 1);

    // two leaves split on x at 0
    clear_mem();
    mem[0] = mk(0, 0, 0, 1);
    mem[1] = mk(1, 0, 0, 11);
    mem[2] = mk(1, 0, 0, 12);
    run_case("R7", -5*ONE, 0, 0, ONE, ONE, ONE, 0, 10*ONE, 32'sh7fffffff, 0);
    chk(obs_ref.size() == 2, "R7", "leaf count", obs_ref.size(), 2);
    if (obs_ref.size() == 2) begin
      chk(obs_ref[0] == 11, "R4", "first leaf", obs_ref[0], 11);
      chk(obs_hi[0] == 5*ONE, "R3", "split t", obs_hi[0], 5*ONE);
    end
    run_case("R5", -5*ONE, 0, 0, ONE, ONE, ONE, 0, 3*ONE, 32'sh7fffffff, 0);
    run_case("R6", -5*ONE, 0, 0, ONE, ONE, ONE, 6*ONE, 10*ONE, 32'sh7fffffff, 0);
    run_case("R4", 5*ONE, 0, 0, -ONE, ONE, ONE, 0, 10*ONE, 32'sh7fffffff, 0);
    if (obs_ref.size() > 0) chk(obs_ref[0] == 12, "R4", "near is upper", obs_ref[0], 12);
    run_case("R8", -5*ONE, 0, 0, 0, ONE, ONE, 0, 10*ONE, 32'sh7fffffff, 0);
    chk(obs_ref.size() == 1, "R8", "parallel leaf count", obs_ref.size(), 1);
    run_case("R5", -5*ONE, 0, 0, -ONE, ONE, ONE, 0, 10*ONE, 32'sh7fffffff, 0);
    run_case("R3", -5*ONE, 0, 0, ONE/2, ONE, ONE, 0, 10*ONE, 32'sh7fffffff, 0);
    if (obs_hi.size() > 0) chk(obs_hi[0] == 5*ONE/2, "R3", "half step", obs_hi[0], 5*ONE/2);
    run_case("R3", -3, 0, 0, 3*ONE + 7, ONE, ONE, -20, 10*ONE, 32'sh7fffffff, 0);

    // z axis through codes 2 and 3
    mem[0] = mk(0, 2, ONE, 1);
    run_case("R2", 0, 0, 0, ONE, ONE, 2*ONE, 0, 10*ONE, 32'sh7fffffff, 0);
    mem[0] = mk(0, 3, ONE, 1);
    run_case("R2", 0, 0, 0, ONE, ONE, 2*ONE, 0, 10*ONE, 32'sh7fffffff, 0);

    // four leaves, x then y
    clear_mem();
    mem[0] = mk(0, 0, 0, 1);
    mem[1] = mk(0, 1, 0, 3);
    mem[2] = mk(0, 1, 0, 5);
    for (int i = 3; i < 7; i++) mem[i] = mk(1, 0, 0, 27 + i);
    run_case("R7", -5*ONE, -5*ONE, 0, ONE, ONE/2, ONE, 0, 10*ONE, 32'sh7fffffff, 0);
    chk(obs_ref.size() == 3, "R6", "leaf count", obs_ref.size(), 3);
    run_case("R10", -5*ONE, -5*ONE, 0, ONE, ONE/2, ONE, 0, 10*ONE, 4*ONE, 0);
    chk(obs_ref.size() == 2, "R10", "early stop count", obs_ref.size(), 2);
    run_case("R10", -5*ONE, -5*ONE, 0, ONE, ONE/2, ONE, 0, 10*ONE, 5*ONE, 0);
    chk(obs_ref.size() == 3, "R10", "equal hit continues", obs_ref.size(), 3);

    // chain deeper than the stack, with a start pulse while busy
    clear_mem();
    for (int j = 0; j < 18; j++) begin
      mem[2*j] = mk(0, 0, 0, 2*j + 2);
      mem[2*j + 3] = mk(1, 0, 0, 100 + j);
    end
    mem[36] = mk(1, 0, 0, 99);
    run_case("R7", -5*ONE, 0, 0, ONE, ONE, ONE, 0, 10*ONE, 32'sh7fffffff, 1);
    chk(obs_ref.size() == 17, "R7", "leaves kept", obs_ref.size(), 17);
    chk(done, "R11", "restart ignored", done, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule